// File: doc/BRIEF.md
# Registered Sum-of-Products Macrocell Array

This block is a programmable sum-of-products logic array. A set of input pins, the flip-flop outputs of every macrocell, and one shared-expander signal per macrocell form the columns of a programmable AND array. Each product term can connect to the true or the complement form of any column. Every macrocell owns a fixed number of product terms. It ORs them, can complement the sum, and either drives the result straight out or registers it in a D flip-flop. The flip-flop value is fed back into the array.

Two term-sharing paths extend a macrocell. A lending macrocell passes its whole sum, including anything lent to it, into the OR of the next macrocell. A macrocell with its shared expander enabled gives up its last product term: that term is evaluated on the pins and the flip-flop feedback only (a first pass), inverted, and offered to every term in the array as an extra column (a second pass). All behaviour comes from one flat configuration vector, so the block is a configurable logic fabric inside a larger design.

Top module: `pal_lab`

## Requirements
- R1: Column c of the array is pin c for c < N_IN, the flip-flop of macrocell c-N_IN for N_IN <= c < N_IN+N_MC, and the shared expander of macrocell c-N_IN-N_MC above that. In a term's mask, bit 2c selects the true form of column c and bit 2c+1 selects its complement. A term with at least one bit set is the AND of its selected literals.
- R2: A product term with an all-zero mask evaluates to 0.
- R3: A macrocell's sum is the OR of its own counted terms and the carry lent to it. Its inversion bit complements that sum before the output and the flip-flop.
- R4: With its bypass bit set, a macrocell's output follows the current inputs within the same cycle. With the bit clear, the output is the flip-flop, which loads the complemented-or-not sum at each rising clock edge.
- R5: While rst is high at a rising edge, every macrocell flip-flop is loaded with 0.
- R6: The feedback columns carry the flip-flop values, not the bypassed combinational values.
- R7: A macrocell with its lend bit set passes its sum (its own terms OR'd with its incoming carry) into the OR of the next-higher macrocell, and its own sum becomes 0. A carry leaving the highest macrocell is dropped. Macrocell 0 receives no carry.
- R8: When the shared-expander bit is set, the macrocell's last term leaves its OR. The macrocell's expander column then carries the complement of that term, evaluated with its connections to shared-expander columns ignored. An all-zero result there gives 1. When the bit is clear, the column is 0.
- R9: Macrocell m occupies configuration bits starting at m*MC_W, where MC_W = N_PT*2*(N_IN+2*N_MC)+4. Term t's mask starts at offset t*2*(N_IN+2*N_MC). The four control bits follow the masks: +0 inversion, +1 bypass, +2 lend, +3 shared-expander enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all macrocell flip-flops |
| rst | input | 1 | Synchronous active-high clear of all flip-flops |
| pins | input | N_IN | Array input pins |
| cfg | input | CFG_W | Flat configuration: term masks and per-macrocell control bits |
| mc_out | output | N_MC | Macrocell outputs |

## Verification
The bench builds the block with 6 pins, 4 terms per macrocell and 16 macrocells, a full logic array block. With these values a lend chain can run through every macrocell, and the dropped carry at the top macrocell is reachable. Every cycle, a bench model that carries its own flip-flop state predicts all 16 outputs. It is driven by sparse random masks and random control bits, with occasional resets. Directed cases cover literal polarity, empty terms, chained lending, a shared expander read by another macrocell, and the one-cycle delay of registered feedback.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef struct packed {
        logic shx_en;
        logic lend;
        logic bypass;
        logic inv;
    } mc_ctrl_t;

    localparam int CTRL_W = $bits(mc_ctrl_t);

    function automatic int true_bit(input int col);
        return 2 * col;
    endfunction

    function automatic int comp_bit(input int col);
        return 2 * col + 1;
    endfunction

endpackage

// File: rtl/pal_pterm.sv
module pal_pterm #(
    parameter int W = 4
) (
    input  logic [2*W-1:0] mask,
    input  logic [W-1:0]   cols,
    output logic           pt
);
    import pal_pkg::*;

    logic [2*W-1:0] lits;

    generate
        for (genvar c = 0; c < W; c++) begin : g_lit
            assign lits[true_bit(c)] = cols[c];
            assign lits[comp_bit(c)] = ~cols[c];
        end
    endgenerate

    // an unconnected term must not disturb the OR
    assign pt = (|mask) & (&(lits | ~mask));

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
    parameter int N_PT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  pal_pkg::mc_ctrl_t ctrl,
    input  logic [N_PT-1:0]   pts,
    input  logic              pt_first,
    input  logic              carry_in,
    output logic              carry_out,
    output logic              shx,
    output logic              q,
    output logic              out
);
    logic [N_PT-1:0] keep;
    logic            own_sum;
    logic            total;
    logic            sum;
    logic            comb;

    always_comb begin
        keep = '1;
        if (ctrl.shx_en) keep[N_PT-1] = 1'b0;
    end

    assign own_sum   = |(pts & keep);
    assign total     = own_sum | carry_in;
    assign sum       = ctrl.lend ? 1'b0 : total;
    assign carry_out = ctrl.lend ? total : 1'b0;
    assign comb      = sum ^ ctrl.inv;
    assign shx       = ctrl.shx_en & ~pt_first;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= comb;
    end

    assign out = ctrl.bypass ? comb : q;

    AST_CLR_Q: assert property (@(posedge clk) rst |=> (q == 1'b0)); // R5
    AST_LEND_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.lend && ctrl.bypass) |-> (out == ctrl.inv)); // R7

endmodule

// File: rtl/pal_lab.sv
module pal_lab #(
    parameter  int N_IN  = 6,
    parameter  int N_PT  = 4,
    parameter  int N_MC  = 16,
    localparam int N_FB  = N_IN + N_MC,
    localparam int NCOL  = N_FB + N_MC,
    localparam int LIT_W = 2 * NCOL,
    localparam int MC_W  = N_PT * LIT_W + pal_pkg::CTRL_W,
    localparam int CFG_W = N_MC * MC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  pins,
    input  logic [CFG_W-1:0] cfg,
    output logic [N_MC-1:0]  mc_out
);
    import pal_pkg::*;

    logic [N_FB-1:0] cols_first;
    logic [NCOL-1:0] cols_full;
    logic [N_MC-1:0] q;
    logic [N_MC-1:0] shx;
    logic [N_MC-1:0] pt_first;
    logic [N_MC-1:0] carry_out;
    mc_ctrl_t        ctrl [N_MC];
    logic [N_PT-1:0] pts [N_MC];

    assign cols_first = {q, pins};
    assign cols_full  = {shx, cols_first};

    generate
        for (genvar m = 0; m < N_MC; m++) begin : g_mc
            localparam int BASE = m * MC_W;
            logic carry_in;

            assign ctrl[m] = mc_ctrl_t'(cfg[BASE + N_PT*LIT_W +: CTRL_W]);

            if (m == 0) begin : g_head
                assign carry_in = 1'b0;
            end else begin : g_link
                assign carry_in = carry_out[m-1];
            end

            pal_pterm #(.W(N_FB)) u_first (
                .mask (cfg[BASE + (N_PT-1)*LIT_W +: 2*N_FB]),
                .cols (cols_first),
                .pt   (pt_first[m])
            );

            for (genvar t = 0; t < N_PT; t++) begin : g_pt
                pal_pterm #(.W(NCOL)) u_pt (
                    .mask (cfg[BASE + t*LIT_W +: LIT_W]),
                    .cols (cols_full),
                    .pt   (pts[m][t])
                );

                always_comb begin
                    if (cfg[BASE + t*LIT_W +: LIT_W] == '0)
                        AST_EMPTY_OFF: assert (pts[m][t] == 1'b0); // R2
                end
            end

            pal_macrocell #(.N_PT(N_PT)) u_mc (
                .clk       (clk),
                .rst       (rst),
                .ctrl      (ctrl[m]),
                .pts       (pts[m]),
                .pt_first  (pt_first[m]),
                .carry_in  (carry_in),
                .carry_out (carry_out[m]),
                .shx       (shx[m]),
                .q         (q[m]),
                .out       (mc_out[m])
            );

            AST_CARRY_ONLY_LEND: assert property (@(posedge clk) disable iff (rst)
                carry_out[m] |-> ctrl[m].lend); // R7
            AST_SHX_IDLE: assert property (@(posedge clk) disable iff (rst)
                !ctrl[m].shx_en |-> !shx[m]); // R8
        end
    endgenerate

endmodule

// File: tb/tb_pal_lab.sv
module tb_pal_lab;
    localparam int NI   = 6;
    localparam int NP   = 4;
    localparam int NM   = 16;
    localparam int NFB  = NI + NM;
    localparam int NCOL = NFB + NM;
    localparam int LITW = 2 * NCOL;
    localparam int MCW  = NP * LITW + 4;
    localparam int CFGW = NM * MCW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NI-1:0]   pins = '0;
    logic [CFGW-1:0] cfg = '0;
    logic [NM-1:0]   mc_out;
    logic [NM-1:0]   mq = '0;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #4 clk = ~clk;

    pal_lab #(.N_IN(NI), .N_PT(NP), .N_MC(NM)) dut (
        .clk(clk), .rst(rst), .pins(pins), .cfg(cfg), .mc_out(mc_out)
    );

    function automatic logic term_val(input logic [LITW-1:0] mask, input logic [NCOL-1:0] cols);
        logic any = 1'b0;
        logic ok  = 1'b1;
        for (int c = 0; c < NCOL; c++) begin
            if (mask[2*c] && !cols[c]) ok = 1'b0;
            if (mask[2*c+1] && cols[c]) ok = 1'b0;
            any = any | mask[2*c] | mask[2*c+1];
        end
        return any & ok;
    endfunction

    function automatic logic [NM-1:0] model_comb(input logic [NI-1:0] p, input logic [NM-1:0] qs);
        logic [NM-1:0]   shx = '0;
        logic [NM-1:0]   res = '0;
        logic [NCOL-1:0] cols;
        logic [LITW-1:0] mk;
        logic [3:0]      ct;
        logic            carry = 1'b0;
        logic            own;
        logic            tot;
        logic            sum;
        cols = {{NM{1'b0}}, qs, p};
        for (int m = 0; m < NM; m++) begin
            ct = cfg[m*MCW + NP*LITW +: 4];
            mk = cfg[m*MCW + (NP-1)*LITW +: LITW];
            mk[LITW-1:2*NFB] = '0;                 // R8: expander columns ignored
            if (ct[3]) shx[m] = ~term_val(mk, cols);
        end
        cols = {shx, qs, p};
        for (int m = 0; m < NM; m++) begin
            ct  = cfg[m*MCW + NP*LITW +: 4];
            own = 1'b0;
            for (int t = 0; t < NP; t++)
                if (!(t == NP-1 && ct[3])) own = own | term_val(cfg[m*MCW + t*LITW +: LITW], cols);
            tot = own | carry;
            if (ct[2]) begin sum = 1'b0; carry = tot; end
            else       begin sum = tot;  carry = 1'b0; end
            res[m] = sum ^ ct[0];
        end
        return res;
    endfunction

    function automatic logic [NM-1:0] model_out();
        logic [NM-1:0] cb = model_comb(pins, mq);
        logic [NM-1:0] o;
        for (int m = 0; m < NM; m++)
            o[m] = cfg[m*MCW + NP*LITW + 1] ? cb[m] : mq[m];
        return o;
    endfunction

    task automatic chk(input string tag, input logic [NM-1:0] got, input logic [NM-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: mc_out=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input int m, input logic exp);
        checks++;
        if (mc_out[m] !== exp) begin
            errors++;
            $display("FAIL %s: mc_out[%0d]=%b expected=%b", tag, m, mc_out[m], exp);
        end
    endtask

    // caller drives at negedge and waits #1 before calling
    task automatic step(input string tag);
        logic [NM-1:0] nxt;
        chk(tag, mc_out, model_out());
        nxt = rst ? '0 : model_comb(pins, mq);
        @(negedge clk);
        mq = nxt;
    endtask

    task automatic set_lit(input int m, input int t, input int c, input bit comp);
        cfg[m*MCW + t*LITW + 2*c + int'(comp)] = 1'b1;
    endtask

    task automatic set_ctl(input int m, input bit inv, input bit byp, input bit lend, input bit shx);
        cfg[m*MCW + NP*LITW +: 4] = {shx, lend, byp, inv};
    endtask

    task automatic rand_cfg();
        for (int m = 0; m < NM; m++) begin
            for (int t = 0; t < NP; t++)
                for (int b = 0; b < LITW; b++)
                    cfg[m*MCW + t*LITW + b] = ($urandom % 24 == 0);
            cfg[m*MCW + NP*LITW +: 4] = 4'($urandom);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a11));
        repeat (3) @(negedge clk);
        mq = '0;
        #1;
        chk("R5 reset state", mc_out, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R9: true literal of pin 0, complement literal of pin 1
        cfg = '0;
        set_lit(0, 0, 0, 1'b0); set_ctl(0, 0, 1, 0, 0);
        set_lit(1, 2, 1, 1'b1); set_ctl(1, 0, 1, 0, 0);
        pins = 6'b000001; #1;
        chk_bit("R1 true literal", 0, 1'b1);
        chk_bit("R1 complement literal", 1, 1'b1);
        step("R9");
        pins = 6'b000010; #1;
        chk_bit("R1 true literal low", 0, 1'b0);
        chk_bit("R1 complement literal high", 1, 1'b0);
        step("R1");

        // R2: empty terms read 0, inversion gives 1
        cfg = '0;
        set_ctl(2, 1, 1, 0, 0);
        #1; chk_bit("R2 empty inverted", 2, 1'b1);
        step("R2");

        // R3: OR of two terms, inverted
        cfg = '0;
        set_lit(10, 0, 4, 0); set_lit(10, 1, 5, 0); set_ctl(10, 1, 1, 0, 0);
        pins = 6'b000000; #1; chk_bit("R3 no term", 10, 1'b1);
        step("R3");
        pins = 6'b100000; #1; chk_bit("R3 second term", 10, 1'b0);
        step("R3");

        // R7: chain 3 -> 4 -> 5, top macrocell lend dropped
        cfg = '0;
        set_lit(3, 0, 0, 0); set_ctl(3, 0, 1, 1, 0);
        set_ctl(4, 0, 1, 1, 0);
        set_ctl(5, 0, 1, 0, 0);
        set_lit(15, 1, 0, 0); set_ctl(15, 0, 1, 1, 0);
        set_ctl(0, 0, 1, 0, 0);
        pins = 6'b000001; #1;
        chk_bit("R7 lender silent", 3, 1'b0);
        chk_bit("R7 middle silent", 4, 1'b0);
        chk_bit("R7 chain end", 5, 1'b1);
        chk_bit("R7 top dropped", 15, 1'b0);
        chk_bit("R7 no wrap", 0, 1'b0);
        step("R7");

        // R8: shared expander of 6 read by 7
        cfg = '0;
        set_lit(6, NP-1, 2, 0); set_lit(6, NP-1, NFB + 6, 0); set_ctl(6, 0, 1, 0, 1);
        set_lit(7, 0, NFB + 6, 0); set_ctl(7, 0, 1, 0, 0);
        pins = 6'b000100; #1;
        chk_bit("R8 term removed", 6, 1'b0);
        chk_bit("R8 expander low", 7, 1'b0);
        step("R8");
        pins = 6'b000000; #1;
        chk_bit("R8 expander high", 7, 1'b1);
        step("R8");

        // R4 R6: registered 8 feeds bypassed 9 one cycle later
        cfg = '0;
        set_lit(8, 0, 3, 0); set_ctl(8, 0, 0, 0, 0);
        set_lit(9, 0, NI + 8, 0); set_ctl(9, 0, 1, 0, 0);
        pins = 6'b001000; #1;
        chk_bit("R4 before edge", 8, 1'b0);
        chk_bit("R6 feedback before edge", 9, 1'b0);
        step("R4");
        #1;
        chk_bit("R4 after edge", 8, 1'b1);
        chk_bit("R6 feedback after edge", 9, 1'b1);
        step("R6");

        // R5: clear a loaded flip-flop
        cfg = '0;
        set_ctl(11, 1, 0, 0, 0);
        #1; step("R5");
        #1; chk_bit("R5 loaded", 11, 1'b1);
        rst = 1'b1; step("R5");
        #1; chk_bit("R5 cleared", 11, 1'b0);
        rst = 1'b0; step("R5");

        // random mix: R1 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 4000; i++) begin
            if (i % 16 == 0) rand_cfg();
            pins = NI'($urandom);
            rst  = ($urandom % 40 == 0);
            #1;
            step("R3 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule